// File: doc/BRIEF.md
# Storage PHY Configuration Register Bank

This block holds the configuration state of a storage-interface PHY behind a small synchronous register bus. It has seven 16-bit control registers and one read-only status word. The control registers feed the PHY's control pins straight from their flops. The status word reports two completion flags that arrive on PHY input pins.

Each bus write carries its own per-bit write enables in the upper half of the data word. Bit x of a control register (x from 0 to 15) takes the new data bit only when bit x+16 of the same write word is set. All other bits keep their value. This lets software change one field, such as the power-up bit or the tap delay select, without first reading the register back.

Reads are registered. The read data appears one clock after the read strobe and holds until the next read strobe.

Top module: `phy_cfg_regbank`

## Requirements
- R1: After reset all seven control registers, every field output and the read data are zero. The PHY therefore starts powered down, with the DLL disabled, frequency code 0 (200 MHz) and impedance code 0 (50 ohm).
- R2: On a write to a control register, data bit x (0 to 15) is stored only if write bit x+16 is 1. Bits whose enable is 0 keep their old value.
- R3: A read of a control register returns its 16 stored bits in bits 15:0, with bits 31:16 reading as zero. The data is valid in the cycle after the read strobe.
- R4: The control registers are at byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18 (word indices 0 to 6). A write to one of them leaves the other six unchanged.
- R5: Register 0x00 drives three fields. Bits 13:12 select the DLL frequency (0 = 200 MHz, 1 = 50 MHz, 2 = 100 MHz, 3 = 150 MHz). Bit 11 enables the output tap delay. Bits 10:7 select the output tap delay.
- R6: Register 0x18 drives three fields. Bit 0 is the active-high power-up control. Bit 1 is the DLL enable. Bits 6:4 select the drive impedance (0 = 50, 1 = 33, 2 = 66, 3 = 100, 4 = 40 ohm).
- R7: A read at offset 0x20 returns calibration-done on bit 6 and DLL-ready on bit 5, both 1 when complete. All other bits read as zero. The returned flags are the input levels present at the clock edge before the read strobe's edge.
- R8: Writes to offset 0x20, to word indices 7 and 9 to 15, or to any address whose two low bits are not zero change no control register.
- R9: Reads of word indices 7 and 9 to 15, or of any address whose two low bits are not zero, return zero.
- R10: The read data holds its value in every cycle without a read strobe, including cycles that carry a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write word: enables in 31:16, data in 15:0 |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration complete flag from the PHY |
| dll_ready_i | input | 1 | DLL lock flag from the PHY |
| pwr_up_o | output | 1 | Analog power-up control |
| dll_en_o | output | 1 | DLL enable |
| dll_freq_sel_o | output | 2 | DLL frequency code |
| drv_imp_sel_o | output | 3 | Drive impedance code |
| otap_en_o | output | 1 | Output tap delay enable |
| otap_sel_o | output | 4 | Output tap delay select |
| ctrl_all_o | output | 112 | All seven control registers, register n in bits 16n+15:16n |

## Verification
The hardest case to reach from the ports is a write whose enables only partly cover its data. The enable mask must split the register into bits that change and bits that hold, with data bits sitting under zero enables, while a shadow copy tracks every register. The random stimulus draws the enable half and the data half independently and also draws unaligned and unmapped addresses. Directed steps then change single fields of registers 0x00 and 0x18 and check the decoded field pins. The status flags are changed only in quiet cycles, followed by a read, so that the one-cycle sampling window stays deterministic.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int BUS_W     = 32;
  localparam int HALF_W    = BUS_W / 2;
  localparam int NUM_CTRL  = 7;
  localparam int STS_INDEX = 8;

  // field positions in control word 0 (clocking)
  localparam int FREQ_LSB  = 12;
  localparam int FREQ_W    = 2;
  localparam int OTEN_BIT  = 11;
  localparam int OTSEL_LSB = 7;
  localparam int OTSEL_W   = 4;

  // field positions in control word 6 (power)
  localparam int PWR_BIT   = 0;
  localparam int DLLEN_BIT = 1;
  localparam int IMP_LSB   = 4;
  localparam int IMP_W     = 3;

  // status word bit positions
  localparam int CAL_BIT   = 6;
  localparam int DLLRDY_BIT = 5;

  typedef logic [HALF_W-1:0] half_t;
endpackage

// File: rtl/cfg_mask_reg.sv
module cfg_mask_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] wr_mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (wr_en) q <= (q & ~wr_mask) | (wr_data & wr_mask);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> q == '0); // R1
  AST_MASK_KEEP: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((q & ~$past(wr_mask)) == ($past(q) & ~$past(wr_mask)))); // R2
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((q & $past(wr_mask)) == ($past(wr_data) & $past(wr_mask)))); // R2
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q)); // R4
endmodule

// File: rtl/cfg_addr_dec.sv
module cfg_addr_dec #(
  parameter int ADDR_W   = 6,
  parameter int NUM_CTRL = 7,
  parameter int STS_IDX  = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_CTRL-1:0] ctrl_hit,
  output logic                sts_hit
);
  localparam int IDX_W = ADDR_W - 2;
  logic [IDX_W-1:0] word_idx;
  logic             aligned;

  assign word_idx = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign sts_hit  = aligned && (word_idx == IDX_W'(STS_IDX));

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_hit
    assign ctrl_hit[i] = aligned && (word_idx == IDX_W'(i));
  end

  always_comb begin
    AST_DEC_ONEHOT: assert ($onehot0({ctrl_hit, sts_hit})); // R4
  end
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux #(
  parameter int NUM_CTRL = 7,
  parameter int HALF_W   = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               re,
  input  logic [NUM_CTRL-1:0]                ctrl_hit,
  input  logic                               sts_hit,
  input  logic [NUM_CTRL-1:0][HALF_W-1:0]    ctrl_q,
  input  logic [2*HALF_W-1:0]                sts_word,
  output logic [2*HALF_W-1:0]                rdata
);
  logic [HALF_W-1:0]   ctrl_sel;
  logic [2*HALF_W-1:0] next_word;

  always_comb begin
    ctrl_sel = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (ctrl_hit[i]) ctrl_sel = ctrl_sel | ctrl_q[i];
    end
    next_word = {{HALF_W{1'b0}}, ctrl_sel} | (sts_hit ? sts_word : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (re) rdata <= next_word;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata)); // R10
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (re && (ctrl_hit != '0)) |=> rdata[2*HALF_W-1:HALF_W] == '0); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (re && (ctrl_hit == '0) && !sts_hit) |=> rdata == '0); // R9
endmodule

// File: rtl/phy_cfg_regbank.sv
module phy_cfg_regbank
  import phy_cfg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BUS_W-1:0]           bus_wdata,
  input  logic                       bus_we,
  input  logic                       bus_re,
  output logic [BUS_W-1:0]           bus_rdata,
  input  logic                       cal_done_i,
  input  logic                       dll_ready_i,
  output logic                       pwr_up_o,
  output logic                       dll_en_o,
  output logic [FREQ_W-1:0]          dll_freq_sel_o,
  output logic [IMP_W-1:0]           drv_imp_sel_o,
  output logic                       otap_en_o,
  output logic [OTSEL_W-1:0]         otap_sel_o,
  output logic [NUM_CTRL*HALF_W-1:0] ctrl_all_o
);
  localparam int CLK_REG = 0;
  localparam int PWR_REG = NUM_CTRL - 1;

  logic [NUM_CTRL-1:0]              ctrl_hit;
  logic                             sts_hit;
  logic [NUM_CTRL-1:0][HALF_W-1:0]  ctrl_q;
  logic                             cal_q, dllrdy_q;
  logic [BUS_W-1:0]                 sts_word;

  cfg_addr_dec #(
    .ADDR_W  (ADDR_W),
    .NUM_CTRL(NUM_CTRL),
    .STS_IDX (STS_INDEX)
  ) u_dec (
    .addr    (bus_addr),
    .ctrl_hit(ctrl_hit),
    .sts_hit (sts_hit)
  );

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
    cfg_mask_reg #(.W(HALF_W)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (bus_we && ctrl_hit[i]),
      .wr_data(bus_wdata[HALF_W-1:0]),
      .wr_mask(bus_wdata[BUS_W-1:HALF_W]),
      .q      (ctrl_q[i])
    );
    assign ctrl_all_o[i*HALF_W +: HALF_W] = ctrl_q[i];
  end

  // status flags captured once so reads see a clean level
  always_ff @(posedge clk) begin
    if (rst) begin
      cal_q    <= 1'b0;
      dllrdy_q <= 1'b0;
    end else begin
      cal_q    <= cal_done_i;
      dllrdy_q <= dll_ready_i;
    end
  end

  always_comb begin
    sts_word             = '0;
    sts_word[CAL_BIT]    = cal_q;
    sts_word[DLLRDY_BIT] = dllrdy_q;
  end

  cfg_rd_mux #(
    .NUM_CTRL(NUM_CTRL),
    .HALF_W  (HALF_W)
  ) u_rd (
    .clk     (clk),
    .rst     (rst),
    .re      (bus_re),
    .ctrl_hit(ctrl_hit),
    .sts_hit (sts_hit),
    .ctrl_q  (ctrl_q),
    .sts_word(sts_word),
    .rdata   (bus_rdata)
  );

  assign dll_freq_sel_o = ctrl_q[CLK_REG][FREQ_LSB +: FREQ_W];
  assign otap_en_o      = ctrl_q[CLK_REG][OTEN_BIT];
  assign otap_sel_o     = ctrl_q[CLK_REG][OTSEL_LSB +: OTSEL_W];
  assign pwr_up_o       = ctrl_q[PWR_REG][PWR_BIT];
  assign dll_en_o       = ctrl_q[PWR_REG][DLLEN_BIT];
  assign drv_imp_sel_o  = ctrl_q[PWR_REG][IMP_LSB +: IMP_W];

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (bus_we && (ctrl_hit == '0)) |=> $stable(ctrl_all_o)); // R8
  AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (bus_re && sts_hit) |=> (bus_rdata[BUS_W-1:CAL_BIT+1] == '0
                            && bus_rdata[DLLRDY_BIT-1:0] == '0)); // R7
  AST_STATUS_VALUE: assert property (@(posedge clk) disable iff (rst)
    (bus_re && sts_hit) |=> bus_rdata[CAL_BIT] == $past(cal_q)); // R7
  AST_PWR_FIELD: assert property (@(posedge clk) disable iff (rst)
    (bus_we && ctrl_hit[PWR_REG] && bus_wdata[HALF_W+PWR_BIT])
      |=> pwr_up_o == $past(bus_wdata[PWR_BIT])); // R6
endmodule

// File: tb/sim_phy_cfg_regbank.sv
module sim_phy_cfg_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        cal_done_i = 1'b0, dll_ready_i = 1'b0;
  logic        pwr_up_o, dll_en_o, otap_en_o;
  logic [1:0]  dll_freq_sel_o;
  logic [2:0]  drv_imp_sel_o;
  logic [3:0]  otap_sel_o;
  logic [111:0] ctrl_all_o;

  int unsigned n_chk = 0, n_bad = 0;
  logic [15:0] mdl [NREG];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_cfg_regbank u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .cal_done_i(cal_done_i), .dll_ready_i(dll_ready_i),
    .pwr_up_o(pwr_up_o), .dll_en_o(dll_en_o), .dll_freq_sel_o(dll_freq_sel_o),
    .drv_imp_sel_o(drv_imp_sel_o), .otap_en_o(otap_en_o), .otap_sel_o(otap_sel_o),
    .ctrl_all_o(ctrl_all_o)
  );

  function automatic logic [15:0] masked(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [31:0] expect_read(input logic [5:0] a);
    if (a[1:0] != 2'b00) return 32'h0;
    if (a[5:2] < NREG) return {16'h0, mdl[a[5:2]]};
    if (a[5:2] == 4'd8) return {25'h0, cal_done_i, dll_ready_i, 5'h0};
    return 32'h0;
  endfunction

  task automatic check(input logic [127:0] got, input logic [127:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] w);
    @(negedge clk);
    bus_addr = a; bus_wdata = w; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    if (a[1:0] == 2'b00 && a[5:2] < NREG) mdl[a[5:2]] = masked(mdl[a[5:2]], w);
  endtask

  task automatic do_read(input logic [5:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    e = expect_read(a);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    check({96'h0, bus_rdata}, {96'h0, e}, tag);
  endtask

  task automatic check_fields(input string tag);
    logic [111:0] all;
    for (int i = 0; i < NREG; i++) all[i*16 +: 16] = mdl[i];
    check({16'h0, ctrl_all_o}, {16'h0, all}, {tag, " R4 all regs"});
    check({115'h0, dll_freq_sel_o, otap_en_o, otap_sel_o, 6'h0},
          {115'h0, mdl[0][13:12], mdl[0][11], mdl[0][10:7], 6'h0}, {tag, " R5 fields"});
    check({122'h0, pwr_up_o, dll_en_o, drv_imp_sel_o, 1'b0},
          {122'h0, mdl[6][0], mdl[6][1], mdl[6][6:4], 1'b0}, {tag, " R6 fields"});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [31:0] held;
    seed = $urandom(32'h5EED_1234);
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check({96'h0, bus_rdata}, 128'h0, "R1 rdata after reset");
    check_fields("R1 reset");
    check({127'h0, pwr_up_o}, 128'h0, "R1 powered down");

    // R5: frequency code 3 (150 MHz), tap enable, tap select 4
    do_write(6'h00, {16'h3F80, 16'h3A00});
    check_fields("R5 directed");
    check({126'h0, dll_freq_sel_o}, 128'h3, "R5 freq code 150MHz");
    check({124'h0, otap_sel_o}, 128'h4, "R5 tap select");
    // R2: change only tap select, others held
    do_write(6'h00, {16'h0780, 16'hFFFF & ~16'h0780});
    check({124'h0, otap_sel_o}, 128'h0, "R2 masked field clear");
    check({126'h0, dll_freq_sel_o}, 128'h3, "R2 unmasked field held");
    // R6: power up only, then DLL enable, impedance 40 ohm (4)
    do_write(6'h18, {16'h0001, 16'hFFFF});
    check({126'h0, pwr_up_o, dll_en_o}, 128'h2, "R6 power up alone");
    do_write(6'h18, {16'h0072, 16'h0042});
    check({125'h0, drv_imp_sel_o}, 128'h4, "R6 impedance 40 ohm");
    check_fields("R6 directed");
    // R3 / R4 reads
    do_write(6'h0C, 32'hFFFF_BEEF);
    do_read(6'h0C, "R3 ctrl read");
    do_read(6'h18, "R3 power reg read");
    check_fields("R4 independence");
    // R8: ignored writes
    do_write(6'h20, 32'hFFFF_FFFF);
    do_write(6'h1C, 32'hFFFF_FFFF);
    do_write(6'h01, 32'hFFFF_FFFF);
    check_fields("R8 ignored writes");
    // R9: unmapped reads
    do_read(6'h3C, "R9 unmapped read");
    do_read(6'h06, "R9 misaligned read");
    // R7: status flags
    @(negedge clk); cal_done_i = 1'b1; dll_ready_i = 1'b0;
    repeat (2) @(negedge clk);
    do_read(6'h20, "R7 cal done only");
    @(negedge clk); cal_done_i = 1'b0; dll_ready_i = 1'b1;
    repeat (2) @(negedge clk);
    do_read(6'h20, "R7 dll ready only");
    // R10: hold across idle and write cycles
    do_read(6'h00, "R3 reg0 read");
    held = bus_rdata;
    do_write(6'h00, 32'hFFFF_0000);
    repeat (3) @(negedge clk);
    check({96'h0, bus_rdata}, {96'h0, held}, "R10 rdata hold");

    // random mix
    for (int k = 0; k < 400; k++) begin
      int unsigned op;
      logic [5:0] a;
      op = $urandom % 8;
      a = {4'($urandom % 16), (($urandom % 6) == 0) ? 2'($urandom) : 2'b00};
      if ($urandom % 2 == 0) a[5:2] = 4'($urandom % 7);
      if (op < 4) begin
        do_write(a, $urandom);
        check_fields("R2 random write");
      end else if (op < 7) begin
        do_read(a, "R3 R9 random read");
      end else begin
        @(negedge clk);
        cal_done_i = 1'($urandom); dll_ready_i = 1'($urandom);
        repeat (2) @(negedge clk);
        do_read(6'h20, "R7 random status");
      end
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule